// File: doc/BRIEF.md
# Triggered Serial Port with Byte Register Access

This block is an asynchronous serial port: one transmit engine and one receive engine behind a byte-wide register port. Software programs the line settings in a configuration register: parity on or off, parity sense, 7- or 8-bit characters, and a forced break. It loads an outgoing byte into a data register. Transmission starts only when software writes a one to a start bit in the command register.

The receive side works the same way. Software arms it with a write-one bit in the command register. An armed receiver delivers exactly one character to the data register and then waits to be armed again. Software reads a command/status register for the busy flags and for sticky frame, parity and overrun flags. The next arm clears those error flags.

The receive path oversamples the line at a fixed multiple of the bit rate and confirms each start bit at its middle. The bit rate is set by parameters and cannot be changed at run time. Read data is registered and is valid one clock after the address is presented.

Top module: `uart_rc_top`

## Requirements
- R1: After reset, the configuration register reads 0x00, the command/status register reads 0x00, and `serial_out` is high.
- R2: The registers are selected by `reg_addr`. Address 0 is configuration: bit 3 = parity on, bit 2 = odd parity, bit 1 = 8-bit characters, bit 0 = break; bits 7:4 read 0. Address 1 is command/status: bit 0 = transmit enable, bit 2 = receive enable, and both read back as written. Address 2 takes the transmit byte on write and returns the received byte on read.
- R3: A write to address 1 with bit 1 and bit 0 set, while the transmitter is idle, starts a frame. `serial_out` goes low in the next cycle and each bit lasts 16×CLKS_PER_TICK clocks. The frame is a low start bit, the data bits least significant first, an optional parity bit, and a high stop bit.
- R4: A start request is ignored while a frame is in progress, and also when bit 0 of the same write is 0. The line and the byte being sent are unaffected.
- R5: With parity on, the parity bit makes the count of ones over data and parity even (bit 2 = 0) or odd (bit 2 = 1). With parity off, no parity bit is sent.
- R6: In 7-bit mode the transmitter sends data bits 6:0 only, and the received byte reads with bit 7 = 0.
- R7: A frame started while the break bit is set drives `serial_out` low for the whole frame, stop position included. The line stays low until the frame has ended and the break bit has been cleared.
- R8: Status bit 1 reads 1 from the cycle after a start is accepted until the stop bit ends. Status bit 3 reads 1 while the receiver is inside a frame.
- R9: An enabled and armed receiver stores the next valid character. A low pulse shorter than half a bit is not taken as a start bit.
- R10: Status bit 6 (frame error) is set when the stop bit is sampled low.
- R11: Status bit 5 (parity error) is set when parity is on and the received parity bit disagrees with the selected sense.
- R12: A character that completes while the receiver is not armed sets status bit 4 (overrun) and leaves the stored byte unchanged.
- R13: A write to address 1 with bits 3 and 2 set arms the receiver and clears status bits 6:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| serial_in | input | 1 | Receive line, idle high |
| serial_out | output | 1 | Transmit line, idle high |

## Verification
The transmit line is due one clock after an accepted start write. Every following bit edge is exactly one bit period later. The bench model therefore advances its bit queue on the same clock edge as the design and compares `serial_out` at every falling edge. Register reads return one cycle after the address is set, so the bench samples `reg_rdata` at the falling edge that follows. Receive results depend on the free-running oversampling phase and arrive at the middle of the stop bit, so the bench reads them only after a full frame plus a fixed margin has passed.

// File: rtl/uart_rc_pkg.sv
package uart_rc_pkg;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic len8;
    logic brk;
  } line_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam logic [1:0] OFS_CFG  = 2'd0;
  localparam logic [1:0] OFS_CMD  = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;

  localparam int FRAME_BITS = 11;

endpackage

// File: rtl/uart_rc_tick.sv
module uart_rc_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      logic          tick_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          tick_q <= (cnt_q == LAST);
          cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      assign tick = tick_q;
    end
  endgenerate

endmodule

// File: rtl/uart_rc_tx.sv
module uart_rc_tx
  import uart_rc_pkg::*;
#(
  parameter int BIT_CLKS = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  line_cfg_t cfg,
  input  logic [7:0] data,
  output logic      busy,
  output logic      line,
  output logic      brk_hold
);

  localparam int CW = $clog2(BIT_CLKS);
  localparam logic [CW-1:0] CNT_LAST = CW'(BIT_CLKS - 1);

  logic [FRAME_BITS-1:0] frame_c;
  logic [3:0]            nbits_c;
  logic [FRAME_BITS-1:0] sh_q;
  logic [3:0]            remain_q;
  logic [CW-1:0]         cnt_q;
  logic                  busy_q;
  logic                  line_q;
  logic                  hold_q;
  logic                  hold_n;
  logic                  accept;
  logic                  pbit;
  logic [3:0]            pidx;

  assign accept = start && !busy_q;

  always_comb begin
    pbit = ^(data & (cfg.len8 ? 8'hFF : 8'h7F)) ^ cfg.par_odd;
    pidx = cfg.len8 ? 4'd9 : 4'd8;
    frame_c    = '1;
    frame_c[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || cfg.len8) frame_c[i+1] = data[i];
    end
    if (cfg.par_en) frame_c[pidx] = pbit;
    if (cfg.brk) frame_c = '0;
    nbits_c = 4'd9 + {3'd0, cfg.len8} + {3'd0, cfg.par_en};
  end

  always_comb begin
    if (accept && cfg.brk)          hold_n = 1'b1;
    else if (!busy_q && !cfg.brk)   hold_n = 1'b0;
    else                            hold_n = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      sh_q     <= '1;
      remain_q <= '0;
      cnt_q    <= '0;
      line_q   <= 1'b1;
      hold_q   <= 1'b0;
    end else begin
      hold_q <= hold_n;
      if (accept) begin
        busy_q   <= 1'b1;
        sh_q     <= frame_c;
        remain_q <= nbits_c;
        cnt_q    <= '0;
        line_q   <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q <= '0;
          if (remain_q == 4'd1) begin
            busy_q <= 1'b0;
            line_q <= ~hold_n;
          end else begin
            sh_q     <= {1'b1, sh_q[FRAME_BITS-1:1]};
            remain_q <= remain_q - 4'd1;
            line_q   <= sh_q[1];
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        line_q <= ~hold_n;
      end
    end
  end

  assign busy     = busy_q;
  assign line     = line_q;
  assign brk_hold = hold_q;

endmodule

// File: rtl/uart_rc_rx.sv
module uart_rc_rx
  import uart_rc_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       line,
  input  logic       len8,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       busy,
  output logic       done,
  output logic [7:0] char_o,
  output logic       ferr,
  output logic       perr
);

  localparam int TW = $clog2(OSR);
  localparam logic [TW-1:0] MID  = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] LAST = TW'(OSR - 1);

  rx_state_e     st_q;
  logic [TW-1:0] tcnt_q;
  logic [2:0]    bidx_q;
  logic [7:0]    sh_q;
  logic          parb_q;
  logic          seen_high_q;
  logic [7:0]    ch_c;
  logic          at_last;

  assign ch_c    = len8 ? sh_q : {1'b0, sh_q[7:1]};
  assign at_last = tick && (tcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= RX_IDLE;
      tcnt_q      <= '0;
      bidx_q      <= '0;
      sh_q        <= '0;
      parb_q      <= 1'b0;
      seen_high_q <= 1'b0;
      done        <= 1'b0;
      char_o      <= '0;
      ferr        <= 1'b0;
      perr        <= 1'b0;
    end else if (!en) begin
      st_q        <= RX_IDLE;
      tcnt_q      <= '0;
      seen_high_q <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (line) seen_high_q <= 1'b1;
      case (st_q)
        RX_IDLE: begin
          if (tick && !line && seen_high_q) begin
            st_q        <= RX_START;
            tcnt_q      <= '0;
            seen_high_q <= 1'b0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt_q == MID) begin
              tcnt_q <= '0;
              bidx_q <= '0;
              st_q   <= line ? RX_IDLE : RX_DATA;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (at_last) begin
            tcnt_q <= '0;
            sh_q   <= {line, sh_q[7:1]};
            if (bidx_q == (len8 ? 3'd7 : 3'd6)) st_q <= par_en ? RX_PAR : RX_STOP;
            else bidx_q <= bidx_q + 3'd1;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_last) begin
            tcnt_q <= '0;
            parb_q <= line;
            st_q   <= RX_STOP;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_last) begin
            tcnt_q <= '0;
            char_o <= ch_c;
            ferr   <= !line;
            perr   <= par_en && (parb_q != (^ch_c ^ par_odd));
            done   <= 1'b1;
            st_q   <= RX_IDLE;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign busy = (st_q != RX_IDLE);

endmodule

// File: rtl/uart_rc_top.sv
module uart_rc_top
  import uart_rc_pkg::*;
#(
  parameter int CLKS_PER_TICK = 2,
  parameter int OSR           = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       serial_in,
  output logic       serial_out
);

  localparam int BIT_CLKS = CLKS_PER_TICK * OSR;

  line_cfg_t  cfg_q;
  logic       tx_en_q, rx_en_q;
  logic [7:0] tx_byte_q, rx_byte_q;
  logic       armed_q, fer_q, per_q, oer_q;
  logic [7:0] rdata_q;
  logic [1:0] sync_q;

  logic       wr_cmd, tx_go, rx_go;
  logic       tick;
  logic       tx_busy_w, tx_hold_w, tx_line_w;
  logic       rx_busy_w, rx_done_w, rx_ferr_w, rx_perr_w;
  logic [7:0] rx_char_w;

  assign wr_cmd = reg_wr && (reg_addr == OFS_CMD);
  assign tx_go  = wr_cmd && reg_wdata[1] && reg_wdata[0];
  assign rx_go  = wr_cmd && reg_wdata[3] && reg_wdata[2];

  uart_rc_tick #(.DIV(CLKS_PER_TICK)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  uart_rc_tx #(.BIT_CLKS(BIT_CLKS)) i_tx (
    .clk      (clk),
    .rst      (rst),
    .start    (tx_go),
    .cfg      (cfg_q),
    .data     (tx_byte_q),
    .busy     (tx_busy_w),
    .line     (tx_line_w),
    .brk_hold (tx_hold_w)
  );

  uart_rc_rx #(.OSR(OSR)) i_rx (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .en      (rx_en_q),
    .line    (sync_q[1]),
    .len8    (cfg_q.len8),
    .par_en  (cfg_q.par_en),
    .par_odd (cfg_q.par_odd),
    .busy    (rx_busy_w),
    .done    (rx_done_w),
    .char_o  (rx_char_w),
    .ferr    (rx_ferr_w),
    .perr    (rx_perr_w)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], serial_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      tx_byte_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CFG:  cfg_q     <= reg_wdata[3:0];
        OFS_CMD:  begin
          tx_en_q <= reg_wdata[0];
          rx_en_q <= reg_wdata[2];
        end
        OFS_DATA: tx_byte_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte_q <= '0;
      armed_q   <= 1'b0;
      fer_q     <= 1'b0;
      per_q     <= 1'b0;
      oer_q     <= 1'b0;
    end else begin
      if (rx_done_w) begin
        if (armed_q) begin
          rx_byte_q <= rx_char_w;
          armed_q   <= 1'b0;
          if (rx_ferr_w) fer_q <= 1'b1;
          if (rx_perr_w) per_q <= 1'b1;
        end else begin
          oer_q <= 1'b1;
        end
      end
      if (rx_go) begin
        armed_q <= 1'b1;
        fer_q   <= 1'b0;
        per_q   <= 1'b0;
        oer_q   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr)
        OFS_CFG:  rdata_q <= {4'd0, cfg_q};
        OFS_CMD:  rdata_q <= {1'b0, fer_q, per_q, oer_q, rx_busy_w, rx_en_q, tx_busy_w, tx_en_q};
        OFS_DATA: rdata_q <= rx_byte_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata  = rdata_q;
  assign serial_out = tx_line_w;

endmodule

// File: rtl/uart_rc_chk.sv
module uart_rc_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [3:0] cmd_bits,
  input logic       serial_out,
  input logic       tx_busy,
  input logic       brk_hold,
  input logic       rx_done,
  input logic       rx_msb,
  input logic       len8,
  input logic       armed,
  input logic       fer,
  input logic       per,
  input logic       oer
);

  logic cmd_wr;
  assign cmd_wr = reg_wr && (reg_addr == 2'd1);

  AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_bits[1] && cmd_bits[0] && !tx_busy) |=> (tx_busy && !serial_out)); // R3

  AST_TX_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_bits[1] && !cmd_bits[0] && !tx_busy) |=> !tx_busy); // R4

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && !brk_hold) |-> serial_out); // R1

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    brk_hold |-> !serial_out); // R7

  AST_SEVEN_BIT_MSB: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !len8) |-> !rx_msb); // R6

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !armed && !(cmd_wr && cmd_bits[3] && cmd_bits[2])) |=> oer); // R12

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_bits[3] && cmd_bits[2]) |=> !(fer || per || oer)); // R13

endmodule

bind uart_rc_top uart_rc_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .cmd_bits   (reg_wdata[3:0]),
  .serial_out (serial_out),
  .tx_busy    (tx_busy_w),
  .brk_hold   (tx_hold_w),
  .rx_done    (rx_done_w),
  .rx_msb     (rx_char_w[7]),
  .len8       (cfg_q.len8),
  .armed      (armed_q),
  .fer        (fer_q),
  .per        (per_q),
  .oer        (oer_q)
);

// File: tb/test_uart_rc_top.sv
`timescale 1ns/100ps
module test_uart_rc_top;

  localparam int CPT = 2;
  localparam int OSR = 16;
  localparam int BIT = CPT * OSR;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rd;
  logic       so;
  logic       loop_on = 1'b1;
  logic       drv = 1'b1;
  logic       si;

  assign si = loop_on ? so : drv;

  always #2.5 clk = ~clk;

  uart_rc_top #(.CLKS_PER_TICK(CPT), .OSR(OSR)) i_uart_rc_top (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (wr),
    .reg_addr   (addr),
    .reg_wdata  (wd),
    .reg_rdata  (rd),
    .serial_in  (si),
    .serial_out (so)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural model of the transmit line: a queue of bits, one per bit period.
  bit         m_q[$];
  int         m_cnt;
  bit         m_busy, m_hold, m_line, m_txen;
  logic [3:0] m_cfg;
  logic [7:0] m_dat;
  bit         m_ob, m_obrk, m_acc, m_bit;
  int         m_len;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_cnt = 0; m_busy = 0; m_hold = 0; m_line = 1; m_txen = 0;
      m_cfg = 4'd0; m_dat = 8'd0;
    end else begin
      m_ob   = m_busy;
      m_obrk = m_cfg[0];
      m_acc  = wr && addr == 2'd1 && wd[1] && wd[0] && !m_ob;
      if (m_ob) begin
        m_cnt++;
        if (m_cnt == BIT) begin
          m_cnt = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_busy = 0;
        end
      end
      if (m_acc) begin
        m_len = m_cfg[1] ? 8 : 7;
        m_q.push_back(1'b0);
        for (int i = 0; i < m_len; i++) m_q.push_back(m_obrk ? 1'b0 : m_dat[i]);
        if (m_cfg[3]) begin
          m_bit = 1'b0;
          for (int i = 0; i < m_len; i++) m_bit = m_bit ^ m_dat[i];
          m_q.push_back(m_obrk ? 1'b0 : (m_bit ^ m_cfg[2]));
        end
        m_q.push_back(m_obrk ? 1'b0 : 1'b1);
        m_busy = 1; m_cnt = 0;
      end
      if (m_acc && m_obrk) m_hold = 1;
      else if (!m_ob && !m_obrk) m_hold = 0;
      if (wr && addr == 2'd0) m_cfg = wd[3:0];
      if (wr && addr == 2'd1) m_txen = wd[0];
      if (wr && addr == 2'd2) m_dat = wd;
      m_line = m_busy ? m_q[0] : !m_hold;
    end
  end

  // Line comparison on every clock covers the frame shape (R3), parity (R5), break (R7).
  always @(negedge clk) begin
    if (!rst) chk("R3/R5/R7 serial_out vs model", int'(so), int'(m_line));
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wd = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rd;
  endtask

  task automatic wait_tx_idle();
    do @(negedge clk); while (m_busy);
    repeat (40) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit with_par, input bit pbit);
    drv = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv = d[i]; repeat (BIT) @(negedge clk);
    end
    if (with_par) begin
      drv = pbit; repeat (BIT) @(negedge clk);
    end
    drv = 1'b1; repeat (2 * BIT) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [7:0] v;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_reg(2'd0, v); chk("R1 cfg reset", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 status reset", v, 8'h00);
    chk("R1 line idle", so, 1);

    // R2 register map
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, v); chk("R2 cfg upper bits", v, 8'h0F);
    wr_reg(2'd0, 8'h02);
    wr_reg(2'd1, 8'h0D); rd_reg(2'd1, v); chk("R2 enables readback", v, 8'h05);

    // R3/R8/R9 loopback 8-bit, no parity
    wr_reg(2'd2, 8'hA5); wr_reg(2'd1, 8'h07);
    repeat (50) @(negedge clk);
    rd_reg(2'd1, v); chk("R8 busy flags mid frame", v, 8'h0F);
    wait_tx_idle();
    rd_reg(2'd2, v); chk("R9 received byte", v, 8'hA5);
    rd_reg(2'd1, v); chk("R8 idle status", v, 8'h05);

    // R4 retrigger while busy is ignored
    wr_reg(2'd1, 8'h0D);
    wr_reg(2'd2, 8'h11); wr_reg(2'd1, 8'h07);
    repeat (20) @(negedge clk);
    wr_reg(2'd2, 8'h99); wr_reg(2'd1, 8'h07);
    wait_tx_idle();
    rd_reg(2'd2, v); chk("R4 busy retrigger ignored", v, 8'h11);
    // R4 trigger without enable
    wr_reg(2'd1, 8'h06);
    repeat (100) @(negedge clk);
    chk("R4 line stays idle", so, 1);
    rd_reg(2'd1, v); chk("R4 no busy without enable", v, 8'h04);

    // R5 even then odd parity
    wr_reg(2'd0, 8'h0A); wr_reg(2'd1, 8'h0D);
    wr_reg(2'd2, 8'h07); wr_reg(2'd1, 8'h07);
    wait_tx_idle();
    rd_reg(2'd1, v); chk("R5 even parity accepted", v, 8'h05);
    wr_reg(2'd0, 8'h0E); wr_reg(2'd1, 8'h0D);
    wr_reg(2'd1, 8'h07);
    wait_tx_idle();
    rd_reg(2'd1, v); chk("R5 odd parity accepted", v, 8'h05);
    rd_reg(2'd2, v); chk("R5 parity byte", v, 8'h07);

    // R6 seven-bit mode
    wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'h0D);
    wr_reg(2'd2, 8'hFF); wr_reg(2'd1, 8'h07);
    wait_tx_idle();
    rd_reg(2'd2, v); chk("R6 seven-bit msb zero", v, 8'h7F);

    // R7/R10 break
    wr_reg(2'd0, 8'h01); wr_reg(2'd1, 8'h0D); wr_reg(2'd1, 8'h07);
    wait_tx_idle();
    chk("R7 line held low", so, 0);
    rd_reg(2'd1, v); chk("R10 frame error", v, 8'h45);
    rd_reg(2'd2, v); chk("R10 break byte", v, 8'h00);
    wr_reg(2'd0, 8'h00);
    repeat (10) @(negedge clk);
    chk("R7 line released", so, 1);

    // R11/R12/R13 with driven frames
    drv = 1'b1; loop_on = 1'b0;
    wr_reg(2'd0, 8'h0A); wr_reg(2'd1, 8'h0D);
    rd_reg(2'd1, v); chk("R13 arm clears errors", v, 8'h05);
    drive_frame(8'h03, 1'b1, 1'b1);
    rd_reg(2'd1, v); chk("R11 parity error", v, 8'h25);
    rd_reg(2'd2, v); chk("R11 byte stored", v, 8'h03);
    drive_frame(8'h55, 1'b1, 1'b0);
    rd_reg(2'd1, v); chk("R12 overrun", v, 8'h35);
    rd_reg(2'd2, v); chk("R12 byte kept", v, 8'h03);
    wr_reg(2'd1, 8'h0D);
    rd_reg(2'd1, v); chk("R13 rearm clears", v, 8'h05);

    // R9 short glitch is not a start bit
    drv = 1'b0; repeat (4) @(negedge clk); drv = 1'b1;
    repeat (100) @(negedge clk);
    rd_reg(2'd1, v); chk("R9 glitch ignored", v, 8'h05);
    rd_reg(2'd2, v); chk("R9 glitch no data", v, 8'h03);
    drive_frame(8'h3C, 1'b1, 1'b0);
    rd_reg(2'd2, v); chk("R9 still armed", v, 8'h3C);
    rd_reg(2'd1, v); chk("R9 clean status", v, 8'h05);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule